// File: doc/BRIEF.md
# Enhanced Vector Prefix Instruction Parser

This block takes an instruction stream one byte per cycle over a valid/ready handshake and takes apart instructions that start with a four-byte vector prefix. It first checks the escape byte. It then collects the three payload bytes, the opcode and the addressing byte. Depending on the addressing byte, it also takes a scale-index byte and a one-byte or four-byte displacement. When the last byte of an instruction has been taken, the block raises a one-cycle completion strobe. It then presents a decoded record that holds until the next instruction completes.

The record gives five-bit register numbers assembled from bits spread over the payload, addressing and scale-index bytes. It also gives the mask register, the zeroing/merging choice, the vector length, the broadcast bit, the width bit, the opcode map as its escape sequence, and the implied legacy prefix byte. Last, it gives a signed displacement. A short displacement comes out already multiplied by the compressed scale factor. A host front end drives the block after any other prefixes have been stripped. Immediate bytes are not consumed.

Top module: `vpx_parser`

## Requirements
- R1: In the waiting state, a first byte equal to 0x62 starts an instruction. Any other first byte gives a one-cycle `esc_err` pulse in the next cycle and no `done`, and the parser keeps waiting for an escape byte.
- R2: With payload bytes P1, P2 and P3 taken in that order after the escape byte, the register numbers are built as follows. `dst_idx` = {P1[4], P1[7], modrm[5:3]}. `src2_idx` = {P3[3], P2[6:3]}. `rm_idx` = {P1[6], P1[5], modrm[2:0]}. All bits are used without inversion.
- R3: The memory-operand numbers are built as follows. `base_idx` = {0, P1[5], modrm[2:0]}. `gidx_idx` = {0, P1[6], sib[5:3]}. `vidx_idx` = {P3[3], P1[6], sib[5:3]}.
- R4: The remaining fields map as follows. `mask_sel` = P3[2:0]. `zeroing` = P3[7]. `vlen` = P3[6:5]. `bcast` = P3[4]. `wbit` = P2[7].
- R5: The map field P1[1:0] gives `map_esc` of 0x000F for 01, 0x0F38 for 10 and 0x0F3A for 11.
- R6: The field P2[1:0] gives `pfx_byte` of 0x00 for 00, 0x66 for 01, 0xF3 for 10 and 0xF2 for 11.
- R7: `fmt_bad` is set in the record when any of these holds: P1[3:2] is not 00, P2[2] is 0, P1[1:0] is 00, or P3[6:5] is 11. Otherwise it is clear.
- R8: After the opcode comes the addressing byte. A scale-index byte follows it when mod≠11 and r/m=100 (`has_sib` reports this). One displacement byte follows when mod=01. Four displacement bytes follow when mod=10, or when mod=00 with r/m=101. Nothing else follows, and with no displacement `disp` is 0.
- R9: A four-byte displacement arrives least significant byte first and is reported sign-extended, without scaling.
- R10: With `bcast`=0, a one-byte displacement is sign-extended and multiplied by 16, 32 or 64 for `vlen` 00, 01 or 10.
- R11: With `bcast`=1, a one-byte displacement is sign-extended and multiplied by 4 when `wbit`=0, or by 8 when `wbit`=1.
- R12: `done` is high for exactly one cycle, starting the cycle after the last byte is taken, and `in_ready` is low in that cycle. The record outputs change only in a cycle in which `done` is high.
- R13: A synchronous reset returns the parser to the escape-waiting state, clears the record, and leaves `done` and `esc_err` low, even in the middle of an instruction.
- R14: A byte is consumed only in a cycle with `in_valid` and `in_ready` both high. Idle cycles between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser can take a byte |
| done | output | 1 | One-cycle strobe: record updated |
| esc_err | output | 1 | One-cycle strobe: first byte was not the escape |
| fmt_bad | output | 1 | Record has reserved-bit, map or length violation |
| opcode | output | 8 | Opcode byte |
| dst_idx | output | 5 | Register-field register number |
| src2_idx | output | 5 | Second-source register number |
| rm_idx | output | 5 | r/m register number |
| base_idx | output | 5 | Memory base register number |
| gidx_idx | output | 5 | General-purpose index register number |
| vidx_idx | output | 5 | Vector index register number |
| mask_sel | output | 3 | Mask register select |
| zeroing | output | 1 | 1 = zeroing, 0 = merging |
| vlen | output | 2 | Vector length code |
| bcast | output | 1 | Broadcast / rounding bit |
| wbit | output | 1 | Width bit |
| has_sib | output | 1 | Scale-index byte was present |
| map_esc | output | 16 | Opcode map escape sequence, 0 if invalid |
| pfx_byte | output | 8 | Implied legacy prefix, 0 if none |
| disp | output | DISP_W | Sign-extended, scaled displacement |

## Verification
The assertions assume that `in_data` is never unknown while `in_valid` is high. They also assume that the source holds a byte until the cycle in which it is taken. The escape check applies only to bytes offered while the parser is waiting for a first byte. The bench drives every byte on the falling edge, keeps `in_valid` low between instructions and during the completion cycle, and never leaves `in_data` unknown. It also places idle gaps between bytes and a reset in the middle of an instruction, so the handshake and reset properties are exercised and not only met trivially.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 5;
    localparam int DISP_BYTES = 4;
    localparam int DRAW_W     = DISP_BYTES * BYTE_W;
    localparam int DCNT_W     = $clog2(DISP_BYTES + 1);

    typedef enum logic [3:0] {
        ST_ESC   = 4'd0,
        ST_P1    = 4'd1,
        ST_P2    = 4'd2,
        ST_P3    = 4'd3,
        ST_OPC   = 4'd4,
        ST_MODRM = 4'd5,
        ST_SIB   = 4'd6,
        ST_DISP  = 4'd7,
        ST_DONE  = 4'd8
    } vpx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] p1;
        logic [BYTE_W-1:0] p2;
        logic [BYTE_W-1:0] p3;
        logic [BYTE_W-1:0] opc;
        logic [BYTE_W-1:0] modrm;
        logic [BYTE_W-1:0] sib;
        logic [DRAW_W-1:0] draw;
        logic [DCNT_W-1:0] dlen;
    } vpx_raw_t;

    typedef struct packed {
        vpx_state_e        st;
        vpx_raw_t          work;
        vpx_raw_t          rec;
        logic [DCNT_W-1:0] dleft;
        logic              done;
        logic              esc_err;
    } vpx_regs_t;

    function automatic logic sib_follows(input logic [BYTE_W-1:0] modrm);
        return (modrm[7:6] != 2'b11) && (modrm[2:0] == 3'b100);
    endfunction

    function automatic logic [DCNT_W-1:0] disp_count(input logic [BYTE_W-1:0] modrm);
        logic [DCNT_W-1:0] n;
        case (modrm[7:6])
            2'b01:   n = DCNT_W'(1);
            2'b10:   n = DCNT_W'(DISP_BYTES);
            2'b00:   n = (modrm[2:0] == 3'b101) ? DCNT_W'(DISP_BYTES) : '0;
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vpx_field_decode.sv
module vpx_field_decode
    import vpx_pkg::*;
(
    input  vpx_raw_t          raw,
    output logic [IDX_W-1:0]  dst_idx,
    output logic [IDX_W-1:0]  src2_idx,
    output logic [IDX_W-1:0]  rm_idx,
    output logic [IDX_W-1:0]  base_idx,
    output logic [IDX_W-1:0]  gidx_idx,
    output logic [IDX_W-1:0]  vidx_idx,
    output logic [2:0]        mask_sel,
    output logic              zeroing,
    output logic [1:0]        vlen,
    output logic              bcast,
    output logic              wbit,
    output logic              has_sib,
    output logic [15:0]       map_esc,
    output logic [7:0]        pfx_byte,
    output logic              fmt_bad
);

    logic hi_r, hi_x, hi_b, top_r, top_v;
    logic [3:0] vvvv;

    always_comb begin
        hi_r  = raw.p1[7];
        hi_x  = raw.p1[6];
        hi_b  = raw.p1[5];
        top_r = raw.p1[4];
        top_v = raw.p3[3];
        vvvv  = raw.p2[6:3];

        dst_idx  = {top_r, hi_r, raw.modrm[5:3]};
        src2_idx = {top_v, vvvv};
        rm_idx   = {hi_x, hi_b, raw.modrm[2:0]};
        base_idx = {1'b0, hi_b, raw.modrm[2:0]};
        gidx_idx = {1'b0, hi_x, raw.sib[5:3]};
        vidx_idx = {top_v, hi_x, raw.sib[5:3]};

        mask_sel = raw.p3[2:0];
        zeroing  = raw.p3[7];
        vlen     = raw.p3[6:5];
        bcast    = raw.p3[4];
        wbit     = raw.p2[7];
        has_sib  = sib_follows(raw.modrm);

        case (raw.p1[1:0])
            2'b01:   map_esc = 16'h000F;
            2'b10:   map_esc = 16'h0F38;
            2'b11:   map_esc = 16'h0F3A;
            default: map_esc = 16'h0000;
        endcase

        case (raw.p2[1:0])
            2'b01:   pfx_byte = 8'h66;
            2'b10:   pfx_byte = 8'hF3;
            2'b11:   pfx_byte = 8'hF2;
            default: pfx_byte = 8'h00;
        endcase

        fmt_bad = (raw.p1[3:2] != 2'b00)
                | ~raw.p2[2]
                | (raw.p1[1:0] == 2'b00)
                | (raw.p3[6:5] == 2'b11);
    end

endmodule

// File: rtl/vpx_disp_scale.sv
module vpx_disp_scale
    import vpx_pkg::*;
#(
    parameter int DISP_W = 32
) (
    input  logic [DRAW_W-1:0] draw,
    input  logic [DCNT_W-1:0] dlen,
    input  logic [1:0]        vlen,
    input  logic              bcast,
    input  logic              wbit,
    output logic [DISP_W-1:0] disp
);

    localparam int SH_W = 3;

    logic [SH_W-1:0]          sh;
    logic signed [DISP_W-1:0] short_ext;
    logic signed [DISP_W-1:0] long_ext;

    always_comb begin
        if (bcast) begin
            sh = wbit ? SH_W'(3) : SH_W'(2);
        end else begin
            case (vlen)
                2'b00:   sh = SH_W'(4);
                2'b01:   sh = SH_W'(5);
                2'b10:   sh = SH_W'(6);
                default: sh = '0;
            endcase
        end

        short_ext = DISP_W'($signed(draw[BYTE_W-1:0]));
        long_ext  = DISP_W'($signed(draw));

        if (dlen == DCNT_W'(DISP_BYTES)) begin
            disp = long_ext;
        end else if (dlen == DCNT_W'(1)) begin
            disp = short_ext <<< sh;
        end else begin
            disp = '0;
        end
    end

endmodule

// File: rtl/vpx_parser.sv
module vpx_parser
    import vpx_pkg::*;
#(
    parameter logic [7:0] ESC_CODE = 8'h62,
    parameter int         DISP_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              done,
    output logic              esc_err,
    output logic              fmt_bad,
    output logic [7:0]        opcode,
    output logic [4:0]        dst_idx,
    output logic [4:0]        src2_idx,
    output logic [4:0]        rm_idx,
    output logic [4:0]        base_idx,
    output logic [4:0]        gidx_idx,
    output logic [4:0]        vidx_idx,
    output logic [2:0]        mask_sel,
    output logic              zeroing,
    output logic [1:0]        vlen,
    output logic              bcast,
    output logic              wbit,
    output logic              has_sib,
    output logic [15:0]       map_esc,
    output logic [7:0]        pfx_byte,
    output logic [DISP_W-1:0] disp
);

    localparam vpx_regs_t REGS_RST = '0;

    vpx_regs_t         r_q, r_d;
    logic              take;
    logic              fin;
    logic              wait_esc;
    logic [DCNT_W-1:0] n_disp;

    assign in_ready = (r_q.st != ST_DONE);
    assign wait_esc = (r_q.st == ST_ESC);
    assign take     = in_valid & in_ready;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.esc_err = 1'b0;
        fin         = 1'b0;
        n_disp      = disp_count(in_data);

        case (r_q.st)
            ST_ESC: begin
                if (take) begin
                    if (in_data == ESC_CODE) begin
                        r_d.work = '0;
                        r_d.st   = ST_P1;
                    end else begin
                        r_d.esc_err = 1'b1;
                    end
                end
            end
            ST_P1: begin
                if (take) begin
                    r_d.work.p1 = in_data;
                    r_d.st      = ST_P2;
                end
            end
            ST_P2: begin
                if (take) begin
                    r_d.work.p2 = in_data;
                    r_d.st      = ST_P3;
                end
            end
            ST_P3: begin
                if (take) begin
                    r_d.work.p3 = in_data;
                    r_d.st      = ST_OPC;
                end
            end
            ST_OPC: begin
                if (take) begin
                    r_d.work.opc = in_data;
                    r_d.st       = ST_MODRM;
                end
            end
            ST_MODRM: begin
                if (take) begin
                    r_d.work.modrm = in_data;
                    r_d.work.dlen  = n_disp;
                    r_d.work.draw  = '0;
                    r_d.dleft      = n_disp;
                    if (sib_follows(in_data)) begin
                        r_d.st = ST_SIB;
                    end else if (n_disp != '0) begin
                        r_d.st = ST_DISP;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            ST_SIB: begin
                if (take) begin
                    r_d.work.sib = in_data;
                    if (r_q.work.dlen != '0) begin
                        r_d.st = ST_DISP;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            ST_DISP: begin
                if (take) begin
                    if (r_q.work.dlen == DCNT_W'(1)) begin
                        r_d.work.draw[BYTE_W-1:0] = in_data;
                    end else begin
                        r_d.work.draw = {in_data, r_q.work.draw[DRAW_W-1:BYTE_W]};
                    end
                    r_d.dleft = r_q.dleft - DCNT_W'(1);
                    if (r_q.dleft == DCNT_W'(1)) begin
                        fin = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_ESC;
            end
            default: begin
                r_d.st = ST_ESC;
            end
        endcase

        if (fin) begin
            r_d.rec  = r_d.work;
            r_d.done = 1'b1;
            r_d.st   = ST_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign done    = r_q.done;
    assign esc_err = r_q.esc_err;
    assign opcode  = r_q.rec.opc;

    vpx_field_decode u_fields (
        .raw      (r_q.rec),
        .dst_idx  (dst_idx),
        .src2_idx (src2_idx),
        .rm_idx   (rm_idx),
        .base_idx (base_idx),
        .gidx_idx (gidx_idx),
        .vidx_idx (vidx_idx),
        .mask_sel (mask_sel),
        .zeroing  (zeroing),
        .vlen     (vlen),
        .bcast    (bcast),
        .wbit     (wbit),
        .has_sib  (has_sib),
        .map_esc  (map_esc),
        .pfx_byte (pfx_byte),
        .fmt_bad  (fmt_bad)
    );

    vpx_disp_scale #(
        .DISP_W (DISP_W)
    ) u_scale (
        .draw  (r_q.rec.draw),
        .dlen  (r_q.rec.dlen),
        .vlen  (vlen),
        .bcast (bcast),
        .wbit  (wbit),
        .disp  (disp)
    );

endmodule

// File: rtl/vpx_parser_chk.sv
module vpx_parser_chk #(
    parameter logic [7:0] ESC_CODE = 8'h62,
    parameter int         DISP_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        in_data,
    input logic              in_ready,
    input logic              done,
    input logic              esc_err,
    input logic              wait_esc,
    input logic [4:0]        dst_idx,
    input logic [4:0]        src2_idx,
    input logic [DISP_W-1:0] disp
);

    // R1: a wrong first byte is reported one cycle later without completion
    assert_bad_escape_R1: assert property (@(posedge clk) disable iff (rst)
        (wait_esc && in_valid && in_data != ESC_CODE) |=> (esc_err && !done));

    // R1: error and completion strobes never coincide
    assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(done && esc_err));

    // R12: completion strobe lasts one cycle
    assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: no byte is accepted in the completion cycle
    assert_done_stall_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R12: record only moves together with the completion strobe
    assert_record_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(dst_idx) && $stable(src2_idx) && $stable(disp)));

endmodule

bind vpx_parser vpx_parser_chk #(
    .ESC_CODE (ESC_CODE),
    .DISP_W   (DISP_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .done     (done),
    .esc_err  (esc_err),
    .wait_esc (wait_esc),
    .dst_idx  (dst_idx),
    .src2_idx (src2_idx),
    .disp     (disp)
);

// File: tb/vpx_parser_bench.sv
`timescale 1ns/1ps
module vpx_parser_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, done, esc_err, fmt_bad;
    logic [7:0]  opcode;
    logic [4:0]  dst_idx, src2_idx, rm_idx, base_idx, gidx_idx, vidx_idx;
    logic [2:0]  mask_sel;
    logic        zeroing, bcast, wbit, has_sib;
    logic [1:0]  vlen;
    logic [15:0] map_esc;
    logic [7:0]  pfx_byte;
    logic [31:0] disp;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] seq [0:15];

    always #2.5 clk = ~clk;

    vpx_parser u_vpx_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .done(done), .esc_err(esc_err), .fmt_bad(fmt_bad),
        .opcode(opcode), .dst_idx(dst_idx), .src2_idx(src2_idx), .rm_idx(rm_idx),
        .base_idx(base_idx), .gidx_idx(gidx_idx), .vidx_idx(vidx_idx),
        .mask_sel(mask_sel), .zeroing(zeroing), .vlen(vlen), .bcast(bcast),
        .wbit(wbit), .has_sib(has_sib), .map_esc(map_esc), .pfx_byte(pfx_byte),
        .disp(disp)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
    endtask

    // sends seq[0..n-1] with gap idle cycles between bytes, then stops at the done cycle
    task automatic send_seq(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            put(seq[i]);
            if (i != n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R13 done after reset", done, 0);
        chk("R13 esc_err after reset", esc_err, 0);
        chk("R13 ready after reset", in_ready, 1);
        chk("R13 dst cleared", dst_idx, 0);
        chk("R13 disp cleared", disp, 0);
    endtask

    task automatic t_register_form;
        seq[0]=8'h62; seq[1]=8'hA1; seq[2]=8'h55; seq[3]=8'hCD; seq[4]=8'h58; seq[5]=8'hDE;
        send_seq(6, 0);
        chk("R12 done after last byte", done, 1);
        chk("R12 ready low in done", in_ready, 0);
        chk("R2 dst", dst_idx, 11);
        chk("R2 src2", src2_idx, 26);
        chk("R2 rm", rm_idx, 14);
        chk("R4 mask", mask_sel, 5);
        chk("R4 zeroing", zeroing, 1);
        chk("R4 vlen", vlen, 2);
        chk("R4 bcast", bcast, 0);
        chk("R4 wbit", wbit, 0);
        chk("R5 map 0F", map_esc, 16'h000F);
        chk("R6 prefix 66", pfx_byte, 8'h66);
        chk("R7 good record", fmt_bad, 0);
        chk("R8 no disp", disp, 0);
        chk("R8 no sib", has_sib, 0);
        chk("opcode R2", opcode, 8'h58);
        @(negedge clk);
        chk("R12 done one cycle", done, 0);
        chk("R12 record held", dst_idx, 11);
    endtask

    task automatic t_disp8_vector;
        seq[0]=8'h62; seq[1]=8'h52; seq[2]=8'h9E; seq[3]=8'h20; seq[4]=8'h10; seq[5]=8'h7A; seq[6]=8'hFF;
        send_seq(7, 0);
        chk("R12 done disp8", done, 1);
        chk("R2 dst hi bit", dst_idx, 23);
        chk("R2 src2 low", src2_idx, 3);
        chk("R2 rm X bit", rm_idx, 18);
        chk("R3 base", base_idx, 2);
        chk("R5 map 0F38", map_esc, 16'h0F38);
        chk("R6 prefix F3", pfx_byte, 8'hF3);
        chk("R4 wbit set", wbit, 1);
        chk("R10 disp -1 x32", disp, 32'hFFFF_FFE0);
        @(negedge clk);
    endtask

    task automatic t_bcast_sib;
        seq[0]=8'h62; seq[1]=8'h63; seq[2]=8'hFF; seq[3]=8'h19; seq[4]=8'hA2;
        seq[5]=8'h44; seq[6]=8'hAB; seq[7]=8'h03;
        send_seq(8, 0);
        chk("R12 done sib", done, 1);
        chk("R8 sib present", has_sib, 1);
        chk("R3 gidx", gidx_idx, 13);
        chk("R3 vidx", vidx_idx, 29);
        chk("R3 base B bit", base_idx, 12);
        chk("R2 rm", rm_idx, 28);
        chk("R2 src2 all ones", src2_idx, 31);
        chk("R5 map 0F3A", map_esc, 16'h0F3A);
        chk("R6 prefix F2", pfx_byte, 8'hF2);
        chk("R11 disp 3 x8", disp, 32'h18);
        @(negedge clk);
    endtask

    task automatic t_disp32_gaps;
        seq[0]=8'h62; seq[1]=8'h01; seq[2]=8'h04; seq[3]=8'h40; seq[4]=8'h28;
        seq[5]=8'h89; seq[6]=8'h78; seq[7]=8'h56; seq[8]=8'h34; seq[9]=8'h12;
        send_seq(10, 2);
        chk("R14 done with gaps", done, 1);
        chk("R9 disp32 order", disp, 32'h1234_5678);
        chk("R6 no prefix", pfx_byte, 8'h00);
        chk("R2 dst gaps", dst_idx, 1);
        @(negedge clk);
    endtask

    task automatic t_disp32_mod0;
        seq[0]=8'h62; seq[1]=8'h01; seq[2]=8'h04; seq[3]=8'h20; seq[4]=8'h29;
        seq[5]=8'h15; seq[6]=8'hF0; seq[7]=8'hFF; seq[8]=8'hFF; seq[9]=8'hFF;
        send_seq(10, 0);
        chk("R8 mod0 rm5 done", done, 1);
        chk("R9 disp32 unscaled", disp, 32'hFFFF_FFF0);
        @(negedge clk);
    endtask

    task automatic t_bad_escape;
        put(8'hC4);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 esc_err pulse", esc_err, 1);
        chk("R1 no done", done, 0);
        chk("R1 record untouched", disp, 32'hFFFF_FFF0);
        @(negedge clk);
        chk("R1 esc_err one cycle", esc_err, 0);
        seq[0]=8'h62; seq[1]=8'h01; seq[2]=8'h04; seq[3]=8'h00; seq[4]=8'h11; seq[5]=8'h40; seq[6]=8'h02;
        send_seq(7, 0);
        chk("R1 recovers", done, 1);
        chk("R10 disp 2 x16", disp, 32'h20);
        @(negedge clk);
    endtask

    task automatic t_bcast_w0;
        seq[0]=8'h62; seq[1]=8'h01; seq[2]=8'h04; seq[3]=8'h10; seq[4]=8'h11; seq[5]=8'h40; seq[6]=8'h80;
        send_seq(7, 0);
        chk("R11 disp -128 x4", disp, 32'hFFFF_FE00);
        seq[3]=8'h40; seq[6]=8'h01;
        @(negedge clk);
        send_seq(7, 0);
        chk("R10 disp 1 x64", disp, 32'h40);
        @(negedge clk);
    endtask

    task automatic t_sib_no_disp;
        seq[0]=8'h62; seq[1]=8'h01; seq[2]=8'h04; seq[3]=8'h00; seq[4]=8'h11; seq[5]=8'h04; seq[6]=8'h00;
        send_seq(7, 0);
        chk("R8 done right after sib", done, 1);
        chk("R8 sib no disp", disp, 0);
        chk("R8 sib flag", has_sib, 1);
        @(negedge clk);
    endtask

    task automatic t_malformed;
        seq[0]=8'h62; seq[1]=8'h05; seq[2]=8'h04; seq[3]=8'h00; seq[4]=8'h11; seq[5]=8'hC0;
        send_seq(6, 0);
        chk("R7 p1 reserved bit", fmt_bad, 1);
        @(negedge clk);
        seq[1]=8'h01; seq[2]=8'h00;
        send_seq(6, 0);
        chk("R7 p2 fixed one", fmt_bad, 1);
        @(negedge clk);
        seq[1]=8'h00; seq[2]=8'h04;
        send_seq(6, 0);
        chk("R7 map zero", fmt_bad, 1);
        chk("R5 map invalid", map_esc, 0);
        @(negedge clk);
        seq[1]=8'h01; seq[3]=8'h60;
        send_seq(6, 0);
        chk("R7 vlen 11", fmt_bad, 1);
        @(negedge clk);
        seq[3]=8'h00;
        send_seq(6, 0);
        chk("R7 clean", fmt_bad, 0);
        @(negedge clk);
    endtask

    task automatic t_mid_reset;
        put(8'h62);
        put(8'h01);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R13 mid reset no done", done, 0);
        chk("R13 mid reset ready", in_ready, 1);
        chk("R13 mid reset record", opcode, 0);
        seq[0]=8'h62; seq[1]=8'hA1; seq[2]=8'h55; seq[3]=8'hCD; seq[4]=8'h58; seq[5]=8'hDE;
        send_seq(6, 0);
        chk("R13 parse after reset", dst_idx, 11);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_register_form();
        t_disp8_vector();
        t_bcast_sib();
        t_disp32_gaps();
        t_disp32_mod0();
        t_bad_escape();
        t_bcast_w0();
        t_sib_no_disp();
        t_malformed();
        t_mid_reset();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule